// File: doc/BRIEF.md
# Vertical Sync Loss Guard

This block watches an active-low vertical sync input and measures it in horizontal lines, using a one-clock line strobe as the time base. A sync pulse whose width is within the allowed range is treated as a field start. The block passes that field start on as a one-clock vertical reference pulse, and it restarts its loss timer and its free-running field counter from that point.

If no qualifying pulse arrives before the loss timeout for the selected video standard runs out, the block raises a no-signal flag. The same state drives two more outputs: a tri-state enable for the line phase detector and a stop request for the sync separators. The field counter keeps running with its own period throughout. Once the flag is set, each wrap of this counter produces a substitute reference pulse, so the panel drive keeps alternating with no video present. The first substitute pulse comes at the counter wrap that follows the declaration, which is the next field boundary. A qualifying sync pulse ends the no-signal state and realigns the counter in the same step.

Top module: `vsync_loss_guard`

## Requirements
- R1: While rst_ni is low, and directly after it is released, no_sig_o, vref_o, pd_hiz_o and sep_stop_o are all 0.
- R2: vsync_ni is sampled at each strobe, and vsync_ni must be steady for at least 2 clocks before that strobe. A low run on vsync_ni seen at 2 to 10 consecutive strobes is a valid sync. It ends at the first strobe that samples vsync_ni high. In the clock cycle after that strobe, vref_o is 1 for exactly one cycle.
- R3: A low run seen at only 1 strobe, or at 11 or more strobes, produces no vref_o pulse. It also does not restart the loss timer.
- R4: With pal_i=0 (NTSC), no_sig_o rises in the cycle after the 301st strobe that follows the last valid sync or reset, and not earlier.
- R5: With pal_i=1 (PAL), no_sig_o rises after the 360th such strobe, and not earlier.
- R6: With pal_i=0 and no_sig_o set, vref_o pulses after every strobe whose count since the last valid sync or reset is a multiple of 269. The first such pulse is at count 538.
- R7: With pal_i=1 and no_sig_o set, the same holds with period 321. The first such pulse is at count 642.
- R8: A valid sync while no_sig_o is set clears no_sig_o in the same cycle that its vref_o pulse appears. Counting for R4 to R7 then restarts from that strobe.
- R9: pd_hiz_o and sep_stop_o are 1 exactly when no_sig_o is 1.
- R10: While no_sig_o is 0, a counter wrap produces no vref_o pulse, and the cycle in which no_sig_o rises carries no vref_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system clear |
| line_stb_i | input | 1 | One-clock pulse per horizontal line |
| vsync_ni | input | 1 | Vertical sync, active low, asynchronous |
| pal_i | input | 1 | Standard select: 0 NTSC, 1 PAL |
| no_sig_o | output | 1 | No-signal state |
| vref_o | output | 1 | One-clock vertical reference pulse |
| pd_hiz_o | output | 1 | Phase detector output tri-state enable |
| sep_stop_o | output | 1 | Sync separator stop request |

## Verification
A wrong loss count shows up at the ports as a no_sig_o edge on the wrong line. That error is visible within one timeout after the last valid sync. A field counter that is out of phase places the first substitute vref_o on the wrong line, at most one field after the declaration. An error in the width qualifier either drops or adds a vref_o pulse at the strobe that ends the sync pulse. If the qualifier wrongly restarts the timer, the no_sig_o edge moves later by the same number of lines. Each of these faults therefore appears within a few hundred strobes of the stimulus that triggers it.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
  localparam int unsigned NTSC_FREE_LINES = 269;
  localparam int unsigned PAL_FREE_LINES  = 321;
  localparam int unsigned NTSC_LOSS_LINES = 301;
  localparam int unsigned PAL_LOSS_LINES  = 360;
  localparam int unsigned VS_MIN_LINES    = 2;
  localparam int unsigned VS_MAX_LINES    = 10;

  typedef enum logic {STD_NTSC = 1'b0, STD_PAL = 1'b1} std_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/vsync_qual.sv
module vsync_qual
  import nsd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_W       = VS_MIN_LINES,
  parameter int unsigned MAX_W       = VS_MAX_LINES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_stb_i,
  input  logic vsync_ni,
  output logic valid_o
);
  localparam int unsigned WID_W = $clog2(MAX_W + 2);
  localparam logic [WID_W-1:0] WID_SAT = WID_W'(MAX_W + 1);
  localparam logic [WID_W-1:0] WID_MIN = WID_W'(MIN_W);
  localparam logic [WID_W-1:0] WID_MAX = WID_W'(MAX_W);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [WID_W-1:0]       wid_q;
  logic                   vs_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], vsync_ni};
  end

  assign vs_act = ~sync_q[SYNC_STAGES-1];

  // width in lines, saturating one past the upper bound
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wid_q <= '0;
    end else if (line_stb_i) begin
      if (!vs_act)               wid_q <= '0;
      else if (wid_q != WID_SAT) wid_q <= wid_q + WID_W'(1);
    end
  end

  assign valid_o = line_stb_i & ~vs_act & (wid_q >= WID_MIN) & (wid_q <= WID_MAX);
endmodule

// File: rtl/loss_timer.sv
module loss_timer #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_stb_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign expire_o = line_stb_i & ~valid_i & (cnt_inc >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (line_stb_i) begin
      if (valid_i)              cnt_q <= '0;
      else if (cnt_q < limit_i) cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/field_counter.sv
module field_counter #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_stb_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  // >= keeps the wrap alive if the standard changes to a shorter period
  assign wrap_o  = line_stb_i & ~valid_i & (cnt_inc >= {1'b0, period_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (line_stb_i) begin
      if (valid_i || wrap_o) cnt_q <= '0;
      else                   cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/vsync_loss_guard.sv
module vsync_loss_guard
  import nsd_pkg::*;
#(
  parameter int unsigned NTSC_FREE   = NTSC_FREE_LINES,
  parameter int unsigned PAL_FREE    = PAL_FREE_LINES,
  parameter int unsigned NTSC_LOSS   = NTSC_LOSS_LINES,
  parameter int unsigned PAL_LOSS    = PAL_LOSS_LINES,
  parameter int unsigned MIN_W       = VS_MIN_LINES,
  parameter int unsigned MAX_W       = VS_MAX_LINES,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_stb_i,
  input  logic vsync_ni,
  input  logic pal_i,
  output logic no_sig_o,
  output logic vref_o,
  output logic pd_hiz_o,
  output logic sep_stop_o
);
  localparam int unsigned CNT_MAX = umax(umax(NTSC_FREE, PAL_FREE), umax(NTSC_LOSS, PAL_LOSS));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  std_e             std;
  logic [CNT_W-1:0] loss_lim;
  logic [CNT_W-1:0] free_per;
  logic             sync_valid;
  logic             loss_hit;
  logic             field_wrap;
  logic             no_sig_q;
  logic             vref_q;

  assign std = std_e'(pal_i);

  always_comb begin
    unique case (std)
      STD_PAL: begin
        loss_lim = CNT_W'(PAL_LOSS);
        free_per = CNT_W'(PAL_FREE);
      end
      default: begin
        loss_lim = CNT_W'(NTSC_LOSS);
        free_per = CNT_W'(NTSC_FREE);
      end
    endcase
  end

  vsync_qual #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_W      (MIN_W),
    .MAX_W      (MAX_W)
  ) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_stb_i(line_stb_i),
    .vsync_ni  (vsync_ni),
    .valid_o   (sync_valid)
  );

  loss_timer #(.CNT_W(CNT_W)) u_loss (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_stb_i(line_stb_i),
    .valid_i   (sync_valid),
    .limit_i   (loss_lim),
    .expire_o  (loss_hit)
  );

  field_counter #(.CNT_W(CNT_W)) u_field (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_stb_i(line_stb_i),
    .valid_i   (sync_valid),
    .period_i  (free_per),
    .wrap_o    (field_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      no_sig_q <= 1'b0;
      vref_q   <= 1'b0;
    end else begin
      if (sync_valid)    no_sig_q <= 1'b0;
      else if (loss_hit) no_sig_q <= 1'b1;
      // substitute pulse only from a state already declared: next field
      vref_q <= sync_valid | (field_wrap & no_sig_q);
    end
  end

  assign no_sig_o   = no_sig_q;
  assign pd_hiz_o   = no_sig_q;
  assign sep_stop_o = no_sig_q;
  assign vref_o     = vref_q;
endmodule

// File: rtl/vsync_loss_guard_chk.sv
module vsync_loss_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic line_stb_i,
  input logic no_sig_o,
  input logic vref_o,
  input logic pd_hiz_o,
  input logic sep_stop_o
);
  assert_vref_after_stb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vref_o |-> $past(line_stb_i));

  assert_vref_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vref_o |=> !vref_o);

  assert_flag_on_stb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(line_stb_i) |-> $stable(no_sig_o));

  assert_exit_with_vref_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(no_sig_o) |-> vref_o);

  assert_declare_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(no_sig_o) |-> !vref_o);

  assert_outputs_agree_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_hiz_o) |-> $rose(sep_stop_o));
endmodule

bind vsync_loss_guard vsync_loss_guard_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .line_stb_i(line_stb_i),
  .no_sig_o  (no_sig_o),
  .vref_o    (vref_o),
  .pd_hiz_o  (pd_hiz_o),
  .sep_stop_o(sep_stop_o)
);

// File: tb/sim_vsync_loss_guard.sv
`timescale 1ns/1ps
module sim_vsync_loss_guard;
  localparam int LP = 6;  // clocks per line

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic line_stb_i = 1'b0;
  logic vsync_ni = 1'b1;
  logic pal_i = 1'b0;
  logic no_sig_o, vref_o, pd_hiz_o, sep_stop_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  int since;
  int wid_m;
  bit nosig_m;
  int line_no;

  always #2 clk = ~clk;

  vsync_loss_guard u0 (
    .clk_i(clk), .rst_ni(rst_ni), .line_stb_i(line_stb_i), .vsync_ni(vsync_ni),
    .pal_i(pal_i), .no_sig_o(no_sig_o), .vref_o(vref_o), .pd_hiz_o(pd_hiz_o),
    .sep_stop_o(sep_stop_o)
  );

  function automatic int per_of(bit p);
    return p ? 321 : 269;
  endfunction

  function automatic int loss_of(bit p);
    return p ? 360 : 301;
  endfunction

  function automatic string pick_tag(bit valid, bit rej, bit nb, int s, bit p);
    if (valid) return nb ? "R8" : "R2";
    if (rej) return "R3";
    if (nb && (s % per_of(p)) == 0) return p ? "R7" : "R6";
    if (s >= loss_of(p) - 1 && s <= loss_of(p)) return p ? "R5" : "R4";
    if (!nb && (s % per_of(p)) == 0) return "R10";
    return "R9";
  endfunction

  task automatic check_bit(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s line=%0d actual=%0b expected=%0b", tag, what, line_no, act, exp);
    end
  endtask

  task automatic do_reset(bit p);
    @(negedge clk);
    rst_ni = 1'b0; line_stb_i = 1'b0; vsync_ni = 1'b1; pal_i = p;
    repeat (3) @(negedge clk);
    check_bit("R1", "no_sig in reset", no_sig_o, 1'b0);
    check_bit("R1", "vref in reset", vref_o, 1'b0);
    rst_ni = 1'b1;
    since = 0; wid_m = 0; nosig_m = 1'b0; line_no = 0;
    @(negedge clk);
    check_bit("R1", "no_sig after reset", no_sig_o, 1'b0);
    check_bit("R1", "vref after reset", vref_o, 1'b0);
    check_bit("R1", "pd_hiz after reset", pd_hiz_o, 1'b0);
    check_bit("R1", "sep_stop after reset", sep_stop_o, 1'b0);
  endtask

  // one line: set vsync level, strobe, then compare against model
  task automatic do_line(bit vs_act);
    bit valid, rej, nb, vexp;
    string tag;
    vsync_ni = ~vs_act;
    repeat (LP - 1) @(negedge clk);
    line_stb_i = 1'b1;
    @(negedge clk);
    line_stb_i = 1'b0;
    line_no++;
    valid = 1'b0; rej = 1'b0;
    if (vs_act) begin
      if (wid_m < 11) wid_m++;
    end else begin
      valid = (wid_m >= 2 && wid_m <= 10);
      rej = (wid_m > 0) && !valid;
      wid_m = 0;
    end
    nb = nosig_m;
    if (valid) since = 0; else since++;
    vexp = valid || (nb && since > 0 && (since % per_of(pal_i)) == 0);
    if (valid) nosig_m = 1'b0;
    else if (since >= loss_of(pal_i)) nosig_m = 1'b1;
    tag = pick_tag(valid, rej, nb, since, pal_i);
    check_bit(tag, "vref", vref_o, vexp);
    check_bit(tag, "no_sig", no_sig_o, nosig_m);
    check_bit("R9", "pd_hiz", pd_hiz_o, nosig_m);
    check_bit("R9", "sep_stop", sep_stop_o, nosig_m);
  endtask

  task automatic pulse(int w, int gap);
    for (int i = 0; i < w; i++) do_line(1'b1);
    for (int i = 0; i < gap; i++) do_line(1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired line=%0d actual=hung expected=done", line_no);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    // NTSC directed: width bounds, rejects, loss, free run, recovery
    do_reset(1'b0);
    pulse(2, 40);      // R2 lower bound
    pulse(10, 40);     // R2 upper bound
    pulse(1, 40);      // R3 too short
    pulse(11, 850);    // R3 too long; then R4, R6, R10
    pulse(5, 350);     // R8 exit, then re-declare R4
    // PAL directed
    do_reset(1'b1);
    pulse(3, 1000);    // R5, R7
    pulse(4, 30);      // R8
    // seeded random mix
    for (int seg = 0; seg < 8; seg++) begin
      do_reset(1'($urandom_range(0, 1)));
      for (int k = 0; k < 4; k++)
        pulse($urandom_range(1, 12), $urandom_range(20, 420));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule